// File: doc/BRIEF.md
# Sparse Column Multiply-Accumulate Engine

This processing element computes its slice of a sparse matrix-vector product. The weight matrix is held in compressed-column form, and this element owns a subset of the output rows, so every output value it produces is summed entirely inside it. A stream of non-zero input activations arrives, each tagged with its column number. A small queue takes them in so that the element can fall behind its neighbours for a while without stalling the broadcast.

For every activation taken from the queue, the element reads the start and end pointers of that column from two pointer banks in a single access. It then walks the column's packed entries, one per cycle. Each entry carries a 4-bit codebook index and a 4-bit zero-run length. The index selects a shared signed fixed-point weight. That weight is multiplied by the activation, and the product is added with saturation into a local file of output accumulators. An end-of-vector strobe arms a completion flag. The flag rises once all accepted work has drained. Matrix contents are written through a simple load port, and the accumulators are read back through a combinational read port.

Top module: `spmac_pe`

## Requirements
- R1: After reset, `done` is 0, `act_ready` is 1 and every accumulator reads 0. Reset clears the accumulators but not the loaded matrix contents.
- R2: An entry byte holds the codebook index in bits 7:4 and the zero-run count in bits 3:0. The first entry of a column targets row `zero-run`. Each later entry targets the previous row plus its zero-run plus one.
- R3: A pointer written at load address k goes to bank k[0]. Column j covers entries p[j] up to p[j+1]-1. A column whose two pointers are equal changes no accumulator.
- R4: The weight is the signed 16-bit codebook value (8 fractional bits) picked by the entry index. The value added to the target row is (activation × weight) shifted right arithmetically by 8.
- R5: An entry whose index decodes to weight 0 leaves its row unchanged but still advances the row position. This lets zero runs longer than 15 be spanned.
- R6: Every accumulation saturates to the range -32768 … 32767.
- R7: The queue holds 8 pending activations. `act_ready` is 0 only while it is full. Every accepted activation is processed, in the order of acceptance.
- R8: `done` is 1 exactly when an end-of-vector strobe has been seen since reset, the queue is empty and no column walk is in progress.
- R9: Activations that hit the same row through different columns add up in that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activation offered |
| act_ready | output | 1 | Queue can accept an activation |
| act_value | input | 16 | Signed activation, 8 fractional bits |
| act_col | input | 4 | Column index of the activation |
| act_eov | input | 1 | End-of-vector strobe |
| ld_en | input | 1 | Load write enable |
| ld_sel | input | 2 | Load target: 0 pointer, 1 entry, 2 codebook |
| ld_addr | input | 6 | Load address |
| ld_data | input | 16 | Load data (pointer in bits 6:0, entry in bits 7:0) |
| rd_row | input | 5 | Accumulator read row |
| rd_data | output | 16 | Accumulator value of `rd_row` |
| done | output | 1 | All accepted work finished after end-of-vector |

## Verification
The queue's push from the broadcast side and its pop by the walker can fall in the same cycle. This happens when an activation arrives exactly as the last entry of the current column issues. One test keeps offering activations on a 20-entry column without a gap. This fills the queue and holds it at its limit while each column end pops one entry and admits the next. The result is judged by seeing `act_ready` drop and by checking that every row holds the sum of all twelve accepted activations, so no entry was lost or processed twice.

// File: rtl/spmac_pkg.sv
package spmac_pkg;
  typedef enum logic [1:0] {
    LD_PTR = 2'd0,
    LD_ENT = 2'd1,
    LD_CB  = 2'd2
  } ld_tgt_e;

  typedef struct packed {
    logic [3:0] widx;
    logic [3:0] zrun;
  } nz_entry_t;
endpackage

// File: rtl/act_queue.sv
module act_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    if (push) wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
    if (pop)  rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
    case ({push, pop})
      2'b10:   cnt_n = cnt + CW'(1);
      2'b01:   cnt_n = cnt - CW'(1);
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= din;
  end

  assign dout  = slot[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R7
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH - 1) && push && !pop) |=> full);
endmodule

// File: rtl/col_ptr_banks.sv
module col_ptr_banks #(
  parameter int COLS  = 16,
  parameter int PTR_W = 7,
  localparam int COL_W = $clog2(COLS),
  localparam int BD    = COLS / 2 + 1,
  localparam int BAW   = $clog2(BD)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [BAW:0]     wr_addr,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [COL_W-1:0] col,
  output logic [PTR_W-1:0] p_lo,
  output logic [PTR_W-1:0] p_hi
);
  logic [BAW-1:0]   raddr [2];
  logic [PTR_W-1:0] rdat  [2];

  // even bank steps one row further when the column is odd
  assign raddr[0] = col[0] ? BAW'(col >> 1) + BAW'(1) : BAW'(col >> 1);
  assign raddr[1] = BAW'(col >> 1);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PTR_W-1:0] mem [BD];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr[0] == 1'(b))) mem[wr_addr[BAW:1]] <= wr_data;
    end
    assign rdat[b] = mem[raddr[b]];
  end

  assign p_lo = col[0] ? rdat[1] : rdat[0];
  assign p_hi = col[0] ? rdat[0] : rdat[1];
endmodule

// File: rtl/col_entry_store.sv
module col_entry_store
  import spmac_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VW      = 16,
  localparam int EAW = $clog2(ENTRIES)
) (
  input  logic           clk,
  input  logic           ent_we,
  input  logic [EAW-1:0] ent_waddr,
  input  nz_entry_t      ent_wdata,
  input  logic           cb_we,
  input  logic [3:0]     cb_waddr,
  input  logic [VW-1:0]  cb_wdata,
  input  logic [EAW-1:0] rd_addr,
  output nz_entry_t      rd_entry,
  output logic [VW-1:0]  weight
);
  nz_entry_t     ents [ENTRIES];
  logic [VW-1:0] book [16];

  always_ff @(posedge clk) begin
    if (ent_we) ents[ent_waddr] <= ent_wdata;
  end

  always_ff @(posedge clk) begin
    if (cb_we) book[cb_waddr] <= cb_wdata;
  end

  assign rd_entry = ents[rd_addr];
  assign weight   = book[rd_entry.widx];
endmodule

// File: rtl/acc_file.sv
module acc_file #(
  parameter int ROWS = 32,
  parameter int VW   = 16,
  parameter int FRAC = 8,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [VW-1:0] act,
  input  logic [VW-1:0] wgt,
  input  logic [RW-1:0] rd_row,
  output logic [VW-1:0] rd_val
);
  logic [VW-1:0]          acc [ROWS];
  logic [VW-1:0]          cur, nv;
  logic signed [2*VW-1:0] prod, scaled;
  logic signed [2*VW+1:0] sum;

  always_comb begin
    cur    = acc[row];
    prod   = $signed({{VW{act[VW-1]}}, act}) * $signed({{VW{wgt[VW-1]}}, wgt});
    scaled = prod >>> FRAC;
    sum    = $signed({{2{scaled[2*VW-1]}}, scaled}) + $signed({{(VW+2){cur[VW-1]}}, cur});
    if (&sum[2*VW+1:VW-1] || ~|sum[2*VW+1:VW-1]) nv = sum[VW-1:0];
    else if (sum[2*VW+1])                          nv = {1'b1, {(VW-1){1'b0}}};
    else                                           nv = {1'b0, {(VW-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) acc[i] <= '0;
    end else if (we) begin
      acc[row] <= nv;
    end
  end

  assign rd_val = acc[rd_row];

  // R6
  mac_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !scaled[2*VW-1]) |=> $signed(acc[$past(row)]) >= $signed($past(cur)));
endmodule

// File: rtl/spmac_pe.sv
module spmac_pe
  import spmac_pkg::*;
#(
  parameter int COLS    = 16,
  parameter int ENTRIES = 64,
  parameter int ROWS    = 32,
  parameter int QDEPTH  = 8,
  parameter int VW      = 16,
  parameter int FRAC    = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS),
  localparam int LD_AW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  output logic             act_ready,
  input  logic [VW-1:0]    act_value,
  input  logic [COL_W-1:0] act_col,
  input  logic             act_eov,
  input  logic             ld_en,
  input  logic [1:0]       ld_sel,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [VW-1:0]    ld_data,
  input  logic [ROW_W-1:0] rd_row,
  output logic [VW-1:0]    rd_data,
  output logic             done
);
  localparam int PTR_W = $clog2(ENTRIES + 1);
  localparam int BAW   = $clog2(COLS / 2 + 1);
  localparam int QW    = COL_W + VW;

  logic             q_push, q_pop, q_empty, q_full;
  logic [QW-1:0]    q_head;
  logic [COL_W-1:0] head_col;
  logic [VW-1:0]    head_val;
  logic [PTR_W-1:0] p_lo, p_hi;
  nz_entry_t        ent;
  logic [VW-1:0]    weight;

  logic             cur_valid, cv_n;
  logic [VW-1:0]    cur_val, val_n;
  logic [PTR_W-1:0] ptr, ptr_n, pend, pend_n;
  logic [ROW_W-1:0] base, base_n, row;
  logic             issue, last, advance;
  logic             eov_seen;

  assign act_ready = !q_full;
  assign q_push    = act_valid && act_ready;
  assign head_col  = q_head[VW +: COL_W];
  assign head_val  = q_head[VW-1:0];

  act_queue #(.DEPTH(QDEPTH), .W(QW)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din({act_col, act_value}),
    .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full)
  );

  col_ptr_banks #(.COLS(COLS), .PTR_W(PTR_W)) u_ptrs (
    .clk(clk), .wr_en(ld_en && ld_sel == LD_PTR), .wr_addr(ld_addr[BAW:0]),
    .wr_data(ld_data[PTR_W-1:0]), .col(head_col), .p_lo(p_lo), .p_hi(p_hi)
  );

  col_entry_store #(.ENTRIES(ENTRIES), .VW(VW)) u_store (
    .clk(clk), .ent_we(ld_en && ld_sel == LD_ENT), .ent_waddr(ld_addr),
    .ent_wdata(ld_data[7:0]), .cb_we(ld_en && ld_sel == LD_CB),
    .cb_waddr(ld_addr[3:0]), .cb_wdata(ld_data),
    .rd_addr(ptr[LD_AW-1:0]), .rd_entry(ent), .weight(weight)
  );

  acc_file #(.ROWS(ROWS), .VW(VW), .FRAC(FRAC)) u_acc (
    .clk(clk), .rst_n(rst_n), .we(issue), .row(row), .act(cur_val),
    .wgt(weight), .rd_row(rd_row), .rd_val(rd_data)
  );

  assign row     = base + ROW_W'(ent.zrun);
  assign issue   = cur_valid && (ptr != pend);
  assign last    = issue && ((ptr + PTR_W'(1)) == pend);
  assign advance = !cur_valid || (ptr == pend) || last;
  assign q_pop   = advance && !q_empty;

  always_comb begin
    cv_n   = cur_valid;
    val_n  = cur_val;
    ptr_n  = ptr;
    pend_n = pend;
    base_n = base;
    if (issue) begin
      ptr_n  = ptr + PTR_W'(1);
      base_n = row + ROW_W'(1);
    end
    if (advance) begin
      if (!q_empty) begin
        cv_n   = 1'b1;
        val_n  = head_val;
        ptr_n  = p_lo;
        pend_n = p_hi;
        base_n = '0;
      end else begin
        cv_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
      cur_val   <= '0;
      ptr       <= '0;
      pend      <= '0;
      base      <= '0;
      eov_seen  <= 1'b0;
    end else begin
      cur_valid <= cv_n;
      cur_val   <= val_n;
      ptr       <= ptr_n;
      pend      <= pend_n;
      base      <= base_n;
      if (act_eov) eov_seen <= 1'b1;
    end
  end

  assign done = eov_seen && q_empty && !cur_valid;

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid |-> ptr <= pend);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> act_ready);
endmodule

// File: tb/spmac_pe_test.sv
`timescale 1ns/1ps
module spmac_pe_test;
  logic        clk = 1'b0;
  logic        rst_n, act_valid, act_eov, ld_en, act_ready, done;
  logic [15:0] act_value, ld_data, rd_data;
  logic [3:0]  act_col;
  logic [1:0]  ld_sel;
  logic [5:0]  ld_addr;
  logic [4:0]  rd_row;

  int n_chk = 0;
  int n_bad = 0;
  int cb [16];
  int pt [17];
  logic [7:0] ent [28];
  longint expv [32];
  bit saw_stall;

  always #2.5 clk = ~clk;

  spmac_pe uut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_ready(act_ready),
    .act_value(act_value), .act_col(act_col), .act_eov(act_eov),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_row(rd_row), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input string req, input longint got, input longint expd);
    n_chk++;
    if (got != expd) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, expd);
    end
  endtask

  task automatic chk_row(input string req, input int r);
    @(negedge clk);
    rd_row = 5'(r);
    #0.5;
    chk(req, longint'($signed(rd_data)), expv[r]);
  endtask

  function automatic longint clamp(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // model of one accepted activation, built from R2..R6
  task automatic model_apply(input int col, input logic [15:0] a);
    int base = 0;
    for (int k = pt[col]; k < pt[col+1]; k++) begin
      int r = base + int'(ent[k][3:0]);
      longint prod = longint'($signed(a)) * longint'(cb[ent[k][7:4]]);
      expv[r] = clamp(expv[r] + (prod >>> 8));
      base = r + 1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; act_valid = 0; act_eov = 0; ld_en = 0;
    act_value = '0; act_col = '0; ld_sel = '0; ld_addr = '0; ld_data = '0; rd_row = '0;
    for (int i = 0; i < 32; i++) expv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_word(input logic [1:0] sel, input int a, input int d);
    ld_en = 1; ld_sel = sel; ld_addr = 6'(a); ld_data = 16'(d);
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 16; i++) load_word(2'd2, i, cb[i]);
    for (int i = 0; i < 17; i++) load_word(2'd0, i, pt[i]);
    for (int i = 0; i < 28; i++) load_word(2'd1, i, int'(ent[i]));
  endtask

  task automatic push_act(input logic [15:0] v, input int c);
    logic took = 0;
    act_valid = 1; act_value = v; act_col = 4'(c);
    while (!took) begin
      took = act_ready;
      if (!took) saw_stall = 1;
      @(negedge clk);
    end
    act_valid = 0;
    model_apply(c, v);
  endtask

  task automatic pulse_eov();
    act_eov = 1;
    @(negedge clk);
    act_eov = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    chk(req, longint'(done), 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done", longint'(done), 0);
    chk("R1 ready", longint'(act_ready), 1);
    chk_row("R1 row0", 0);
    chk_row("R1 row31", 31);
  endtask

  task automatic t_single();
    do_reset();
    push_act(16'h0100, 0);
    repeat (12) @(negedge clk);
    chk("R8 no eov", longint'(done), 0);
    pulse_eov();
    wait_done("R8 done");
    chk_row("R2 first row", 0);
    chk_row("R2 skip row", 3);
    chk_row("R2 third row", 5);
    chk_row("R2 untouched", 1);
    chk("R4 neg weight", expv[5], -256);
  endtask

  task automatic t_multi();
    do_reset();
    push_act(16'h0300, 2);
    push_act(16'h0100, 1);
    push_act(16'hFE80, 0);
    push_act(16'h0200, 3);
    push_act(16'h0100, 2);
    pulse_eov();
    wait_done("R8 multi");
    chk_row("R4 half weight", 1);
    chk_row("R9 shared row", 5);
    chk_row("R5 padding row", 15);
    chk_row("R5 after padding", 19);
    for (int r = 0; r < 32; r++) chk_row("R3 all rows", r);
  endtask

  task automatic t_sat();
    do_reset();
    push_act(16'h4000, 4);
    pulse_eov();
    wait_done("R8 sat");
    chk_row("R6 high clamp", 0);
    chk("R6 high value", expv[0], 32767);
    push_act(16'hC000, 4);
    push_act(16'hC000, 4);
    wait_done("R8 sat2");
    chk_row("R6 low clamp", 0);
    chk("R6 low value", expv[0], -32768);
  endtask

  task automatic t_queue();
    do_reset();
    saw_stall = 0;
    for (int i = 0; i < 12; i++) push_act(16'h0040, 5);
    pulse_eov();
    wait_done("R8 queue");
    chk("R7 stall seen", longint'(saw_stall), 1);
    for (int r = 0; r < 21; r++) chk_row("R7 row sum", r);
    chk("R7 sum value", expv[0], 768);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) cb[i] = i * 100 - 900;
    cb[0] = 0; cb[1] = 256; cb[2] = 512; cb[3] = -256; cb[4] = 128; cb[5] = 32767;
    pt[0] = 0; pt[1] = 3; pt[2] = 3; pt[3] = 5; pt[4] = 7; pt[5] = 8;
    for (int i = 6; i < 17; i++) pt[i] = 28;
    ent[0] = 8'h10; ent[1] = 8'h22; ent[2] = 8'h31; ent[3] = 8'h41;
    ent[4] = 8'h23; ent[5] = 8'h0F; ent[6] = 8'h13; ent[7] = 8'h50;
    for (int i = 8; i < 28; i++) ent[i] = 8'h10;
    do_reset();
    load_all();
    t_reset();
    t_single();
    t_multi();
    t_sat();
    t_queue();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule